// File: doc/BRIEF.md
# Parallel EPROM Single-Word Read Controller

This block sits between a synchronous host port and an asynchronous 64K x 16 parallel read-only memory that has separate active-low chip-enable and output-enable lines. The host presents a 16-bit word address with a request while `ready` is high. The controller then drives the address and pulls chip-enable low. It lowers output-enable only once enough time is left for the output-enable path to finish together with the address path. It captures the data word when both access times have elapsed and returns it with a one-cycle `rvalid` pulse.

All bus timing comes from nanosecond figures for the chosen speed grade (45/20/20 ns for address access, output-enable access and output float on the fast grade; 70/25/25 ns on the slow grade) and the clock-period parameter. Each figure is rounded up to whole cycles with a floor of one. After the capture, chip-enable and output-enable are released together. The controller then holds `ready` low until the memory's output drivers are guaranteed to have let go of the data bus. Only after that can the next access start.

Top module: `eprom_rd_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `memCeN` and `memOeN` are 1, `rvalid` is 0 and `ready` is 1.
- R2: A request sampled at a clock edge with `ready` high puts `addr` on `memAddr`, drives `memCeN` to 0 and drives `ready` to 0 from that edge on.
- R3: `memOeN` falls exactly OE_LEAD cycles after `memCeN` falls, where OE_LEAD = max(1, accCyc - oeCyc). With the fast grade and a 10 ns clock, accCyc = 5, oeCyc = 2 and OE_LEAD = 3.
- R4: `memOeN` is never 0 while `memCeN` is 1.
- R5: The data word is captured at the edge max(accCyc, OE_LEAD + oeCyc) cycles after `memCeN` falls (5 cycles by default). `rdata` then equals the word the memory drove just before that edge, and `rvalid` is high for exactly one cycle.
- R6: `memCeN` and `memOeN` both return to 1 at the capture edge, so both are 1 during the `rvalid` cycle.
- R7: `memAddr` holds its value for as long as `memCeN` stays 0.
- R8: `ready` stays 0 for the whole access. It returns to 1 exactly dfCyc cycles after the release edge (dfCyc = 2 by default), so `memCeN` cannot fall again inside the float window.
- R9: A request while `ready` is 0 is ignored: `memAddr` does not change and no extra `rvalid` is produced.
- R10: Reads issued one after another, each accepted as soon as `ready` allows, return their words in issue order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, period CLK_PERIOD_NS |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request, taken when `ready` is high |
| addr | input | ADDR_W | Word address of the request |
| ready | output | 1 | Controller idle and able to take a request |
| rdata | output | DATA_W | Captured data word |
| rvalid | output | 1 | One-cycle strobe marking `rdata` valid |
| memAddr | output | ADDR_W | Address bus to the memory |
| memCeN | output | 1 | Active-low chip enable to the memory |
| memOeN | output | 1 | Active-low output enable to the memory |
| memData | input | DATA_W | Data bus from the memory |

## Verification
Data capture and bus release share one clock edge. A capture that is even one cycle early, or a release that comes first, reads a wrong word. The bench's memory model drives the correct word only while both enables are low and both access times, counted in cycles since each enable fell, have elapsed. At every other moment, including the instant the enables rise, it drives a poison pattern. A stray poison value in `rdata` therefore exposes any misplaced sampling. Back-to-back requests then test whether the float window ends on time with `ready` rising, no earlier and no later.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_OE_WAIT,
    S_RELEASE,
    S_TURN
  } rdState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic capture;
  } dpStrobe_t;

  // Round a nanosecond figure up to whole clock cycles, never below one
  function automatic int nsToCyc(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int accessNs(input bit fast);
    return fast ? 45 : 70;
  endfunction

  function automatic int oeAccessNs(input bit fast);
    return fast ? 20 : 25;
  endfunction

  function automatic int floatNs(input bit fast);
    return fast ? 20 : 25;
  endfunction

  function automatic int oeLeadCyc(input int accC, input int oeC);
    return (accC > oeC) ? (accC - oeC) : 1;
  endfunction

  function automatic int sampleCyc(input int accC, input int oeC);
    int lead;
    lead = oeLeadCyc(accC, oeC);
    return (accC > lead + oeC) ? accC : (lead + oeC);
  endfunction

endpackage

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter bit FAST_GRADE    = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      req,
  output logic      ready,
  output logic      rvalid,
  output logic      memCeN,
  output logic      memOeN,
  output dpStrobe_t strobe
);

  localparam int ACC_CYC   = nsToCyc(accessNs(FAST_GRADE), CLK_PERIOD_NS);
  localparam int OE_CYC    = nsToCyc(oeAccessNs(FAST_GRADE), CLK_PERIOD_NS);
  localparam int DF_CYC    = nsToCyc(floatNs(FAST_GRADE), CLK_PERIOD_NS);
  localparam int OE_LEAD   = oeLeadCyc(ACC_CYC, OE_CYC);
  localparam int SAMPLE_AT = sampleCyc(ACC_CYC, OE_CYC);
  localparam int OE_HOLD   = SAMPLE_AT - OE_LEAD;
  localparam int TURN_LAST = (DF_CYC > 1) ? DF_CYC - 2 : 0;
  localparam int CNT_MAX   = (SAMPLE_AT > DF_CYC) ? SAMPLE_AT : DF_CYC;
  localparam int CNT_W     = $clog2(CNT_MAX + 1) + 1;

  rdState_t         state;
  logic [CNT_W-1:0] cnt;
  logic             leadDone;
  logic             holdDone;
  logic             turnDone;

  assign leadDone = (cnt == CNT_W'(OE_LEAD - 1));
  assign holdDone = (cnt == CNT_W'(OE_HOLD - 1));
  assign turnDone = (cnt == CNT_W'(TURN_LAST));

  assign ready           = (state == S_IDLE);
  assign strobe.loadAddr = (state == S_IDLE) && req;
  assign strobe.capture  = (state == S_OE_WAIT) && holdDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      memCeN <= 1'b1;
      memOeN <= 1'b1;
      rvalid <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req) begin
            state  <= S_ADDR;
            cnt    <= '0;
            memCeN <= 1'b0;
          end
        end
        S_ADDR: begin
          if (leadDone) begin
            state  <= S_OE_WAIT;
            cnt    <= '0;
            memOeN <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_OE_WAIT: begin
          if (holdDone) begin
            state  <= S_RELEASE;
            cnt    <= '0;
            memCeN <= 1'b1;
            memOeN <= 1'b1;
            rvalid <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RELEASE: begin
          cnt   <= '0;
          state <= (DF_CYC > 1) ? S_TURN : S_IDLE;
        end
        S_TURN: begin
          if (turnDone) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eprom_rd_dp.sv
module eprom_rd_dp
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      rdata   <= '0;
    end else begin
      if (strobe.loadAddr) memAddr <= addr;
      if (strobe.capture)  rdata   <= memData;
    end
  end

endmodule

// File: rtl/eprom_rd_top.sv
module eprom_rd_top
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter bit FAST_GRADE    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  input  logic [DATA_W-1:0] memData
);

  dpStrobe_t strobe;

  eprom_rd_ctrl #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .FAST_GRADE   (FAST_GRADE)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .req   (req),
    .ready (ready),
    .rvalid(rvalid),
    .memCeN(memCeN),
    .memOeN(memOeN),
    .strobe(strobe)
  );

  eprom_rd_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .addr   (addr),
    .memData(memData),
    .memAddr(memAddr),
    .rdata  (rdata)
  );

endmodule

// File: rtl/eprom_rd_chk.sv
module eprom_rd_chk
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter bit FAST_GRADE    = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              req,
  input logic              ready,
  input logic              rvalid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memOeN
);

  localparam int ACC_CYC = nsToCyc(accessNs(FAST_GRADE), CLK_PERIOD_NS);
  localparam int OE_CYC  = nsToCyc(oeAccessNs(FAST_GRADE), CLK_PERIOD_NS);
  localparam int OE_LEAD = oeLeadCyc(ACC_CYC, OE_CYC);

  // Cycles elapsed since chip enable went low (saturating)
  logic [7:0] ceLowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ceLowCnt <= '0;
    else if (memCeN)           ceLowCnt <= '0;
    else if (ceLowCnt != 8'hFF) ceLowCnt <= ceLowCnt + 8'd1;
  end

  a_r3_oe_lead: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memOeN) |-> (ceLowCnt == 8'(OE_LEAD)));

  a_r4_oe_within_ce: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memCeN);

  a_r5_rvalid_single: assert property (@(posedge clk) disable iff (!rstN)
    rvalid |=> !rvalid);

  a_r6_release_with_data: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCeN) |-> (rvalid && memOeN));

  a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  a_r8_busy_during_access: assert property (@(posedge clk) disable iff (!rstN)
    !memCeN |-> !ready);

  a_r9_busy_req_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (req && !ready) |=> $stable(memAddr));

endmodule

bind eprom_rd_top eprom_rd_chk #(
  .ADDR_W       (ADDR_W),
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .FAST_GRADE   (FAST_GRADE)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .req    (req),
  .ready  (ready),
  .rvalid (rvalid),
  .memAddr(memAddr),
  .memCeN (memCeN),
  .memOeN (memOeN)
);

// File: tb/eprom_rd_top_bench.sv
module eprom_rd_top_bench;

  localparam int ACC = 5;   // 45 ns at 10 ns
  localparam int OEC = 2;   // 20 ns
  localparam int DF  = 2;   // 20 ns
  localparam int LEAD = 3;
  localparam int SAMP = 5;

  logic        clk = 1'b0;
  logic        rstN;
  logic        req;
  logic [15:0] addr;
  logic        ready;
  logic [15:0] rdata;
  logic        rvalid;
  logic [15:0] memAddr;
  logic        memCeN;
  logic        memOeN;
  logic [15:0] memData;

  int errors = 0;
  int checks = 0;
  int issued = 0;
  int returned = 0;
  bit finished = 1'b0;
  logic [15:0] expQ[$];

  always #5 clk = ~clk;

  eprom_rd_top u_eprom_rd_top (
    .clk(clk), .rstN(rstN), .req(req), .addr(addr), .ready(ready),
    .rdata(rdata), .rvalid(rvalid), .memAddr(memAddr), .memCeN(memCeN),
    .memOeN(memOeN), .memData(memData)
  );

  function automatic logic [15:0] romWord(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'hC35A;
  endfunction

  // Memory model: correct word only once both access times have run out
  int ceCnt = 0;
  int oeCnt = 0;
  always @(posedge clk) begin
    ceCnt <= memCeN ? 0 : ceCnt + 1;
    oeCnt <= memOeN ? 0 : oeCnt + 1;
  end
  always_comb begin
    if (!memCeN && !memOeN && (ceCnt + 1 >= ACC) && (oeCnt + 1 >= OEC))
      memData = romWord(memAddr);
    else
      memData = 16'hBAD0;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Driver: issue one read, push expected word
  task automatic doRead(input logic [15:0] a);
    while (!ready) @(negedge clk);
    req  = 1'b1;
    addr = a;
    expQ.push_back(romWord(a));
    issued++;
    @(negedge clk);
    req = 1'b0;
    check(memAddr == a, "R2 memAddr", memAddr, a);
    check(memCeN == 1'b0, "R2 memCeN", memCeN, 0);
    check(ready == 1'b0, "R2 ready", ready, 0);
  endtask

  // Monitor: scoreboard and bus timing
  int sinceCe = 0;
  int sinceRel = 0;
  logic prevCe = 1'b1, prevOe = 1'b1, prevReady = 1'b1;
  logic [15:0] prevAddr = '0;
  always @(negedge clk) begin
    if (rstN) begin
      sinceCe++;
      sinceRel++;
      if (prevCe && !memCeN) sinceCe = 0;
      if (prevOe && !memOeN)
        check(sinceCe == LEAD, "R3 oe lead", sinceCe, LEAD);
      if (!memOeN && memCeN) check(1'b0, "R4 oe without ce", memOeN, 1);
      if (!memCeN && !prevCe)
        check(memAddr == prevAddr, "R7 addr stable", memAddr, prevAddr);
      if (!memCeN && ready) check(1'b0, "R8 ready in access", ready, 0);
      if (rvalid) begin
        sinceRel = 0;
        check(sinceCe == SAMP, "R5 capture timing", sinceCe, SAMP);
        check(memCeN && memOeN, "R6 release", {memCeN, memOeN}, 3);
        if (expQ.size() == 0) begin
          check(1'b0, "R9 extra rvalid", rdata, 0);
        end else begin
          logic [15:0] e;
          e = expQ.pop_front();
          returned++;
          check(rdata == e, "R5 R10 rdata", rdata, e);
        end
      end
      if (rvalid && prevCe == 1'b0) ; // release edge already counted
      if (!prevReady && ready)
        check(sinceRel == DF, "R8 turnaround", sinceRel, DF);
      prevCe = memCeN;
      prevOe = memOeN;
      prevReady = ready;
      prevAddr = memAddr;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    req  = 1'b0;
    addr = '0;
    repeat (3) @(negedge clk);
    check(memCeN && memOeN, "R1 enables in reset", {memCeN, memOeN}, 3);
    check(!rvalid && ready, "R1 rvalid/ready in reset", {rvalid, ready}, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(memCeN && memOeN && !rvalid && ready, "R1 after reset",
          {memCeN, memOeN, rvalid, ready}, 4'b1101);

    doRead(16'h0000);
    doRead(16'hFFFF);
    doRead(16'h1234);

    // R9: requests while busy must not disturb the access
    doRead(16'h00F0);
    req  = 1'b1;
    addr = 16'h0F0F;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(memAddr == 16'h00F0, "R9 busy req", memAddr, 16'h00F0);
    end
    req = 1'b0;

    // R10: back-to-back reads
    for (int i = 0; i < 6; i++) doRead(16'(i * 16'h1111 + 7));
    doRead(16'hA5C3);

    while (!ready || expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(returned == issued, "R10 count", returned, issued);
    finishRun();
  end

endmodule